// File: doc/BRIEF.md
# Sound Unit I/O Register File

This block holds the control registers and the waveform sample memory of a four-channel sound unit. It sits on the I/O page and is addressed by an 8-bit offset into that page. It only stores and returns register contents. It generates no sound.

Reads are combinational. Each control register returns its stored byte with a fixed per-register set of bits forced to 1, so bits that cannot be read always come back high. The four write-only pitch-low registers return all ones. Two unused offsets inside the control range are accepted: they return all ones, store nothing and raise a note flag. The 16-byte waveform memory is fully readable and writable.

Every write attempt is echoed one cycle later on a log port, whether or not the offset is handled. A silence counter measures the number of cycles since the last accepted write.

Top module: `sound_regfile`

## Requirements
- R1: After a synchronous reset, all control registers and waveform bytes hold zero, `silence_cnt` is 0 and `log_valid` is 0.
- R2: A read of a control register returns its stored byte ORed with a fixed mask, as follows:
  - offset 0x10: 0x80
  - offsets 0x11 and 0x16: 0x3F
  - offsets 0x14, 0x19, 0x1E and 0x23: 0xBF
  - offset 0x1A: 0x7F
  - offset 0x20: 0xC0
  - offset 0x26: 0x70
- R3: Offsets 0x13, 0x18, 0x1D and 0x22 always read 0xFF, whatever was written to them.
- R4: Offsets 0x12, 0x17, 0x1B, 0x1C, 0x21, 0x24 and 0x25 read back exactly the last byte written.
- R5: Offsets 0x15 and 0x1F behave as follows:
  - `hit` is 1 and `note` is 1 when either strobe is high.
  - A read returns 0xFF.
  - Writes are discarded, so the offset still reads 0xFF afterwards.
- R6: Offsets 0x30..0x3F form a 16-byte memory at index (offset − 0x30) that reads back the last byte written.
- R7: Offsets outside 0x10..0x26 and 0x30..0x3F behave as follows:
  - `hit` is 0.
  - A read returns 0xFF.
  - A write changes no state and does not clear the silence counter.
- R8: In the cycle after each write strobe, whether or not the offset is handled, `log_valid` is 1 and `log_addr`/`log_data` carry that write's offset and data. Otherwise `log_valid` is 0.
- R9: An accepted write clears `silence_cnt` to 0 in the following cycle. An accepted write is a write with `hit` = 1, which includes 0x15 and 0x1F.
- R10: In every other cycle `silence_cnt` increments by one. It saturates at 2^CNT_W − 1.
- R11: When a read and a write hit the same offset in one cycle, `rdata` shows the content from before the write. The new content is visible from the next cycle.
- R12: With both strobes low, `hit` and `note` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Offset within the I/O page |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Combinational read data |
| hit | output | 1 | Offset is handled by this block |
| note | output | 1 | Access to an unused offset inside the control range |
| log_valid | output | 1 | A write was attempted in the previous cycle |
| log_addr | output | 8 | Offset of the logged write |
| log_data | output | 8 | Data of the logged write |
| silence_cnt | output | CNT_W | Cycles since the last accepted write |

## Verification
A read and a write to the same offset can fall in one cycle. The bench provokes this by raising both strobes on a plain register that holds a known earlier value. It judges `rdata` in that cycle against the old value, then against the new value one cycle later. A second coincidence occurs between a clearing write and a counter that has already saturated. The bench drives the counter to its ceiling, writes to a handled offset, and expects zero on the next cycle followed by a fresh count.

// File: rtl/sndrf_pkg.sv
`timescale 1ns/1ps
package sndrf_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_CTRL = 2'd1,
      SLOT_HOLE = 2'd2,
      SLOT_WAVE = 2'd3
   } slot_e;

   // Offsets inside the control range that own no storage
   function automatic logic is_hole(input logic [7:0] ofs);
      return (ofs == 8'h15) || (ofs == 8'h1F);
   endfunction

   // Bits forced high on readback, keyed by page offset
   function automatic logic [7:0] ctrl_read_mask(input logic [7:0] ofs);
      logic [7:0] m;
      case (ofs)
         8'h10:                      m = 8'h80;
         8'h11, 8'h16:               m = 8'h3F;
         8'h14, 8'h19, 8'h1E, 8'h23: m = 8'hBF;
         8'h1A:                      m = 8'h7F;
         8'h20:                      m = 8'hC0;
         8'h26:                      m = 8'h70;
         8'h13, 8'h18, 8'h1D, 8'h22: m = 8'hFF;
         default:                    m = 8'h00;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/sndrf_decode.sv
`timescale 1ns/1ps
module sndrf_decode
   import sndrf_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int CTRL_FIRST = 16,
   parameter int CTRL_LAST  = 38,
   parameter int WAVE_BASE  = 48,
   parameter int WAVE_DEPTH = 16,
   parameter int CIDX_W     = 5,
   parameter int WIDX_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output slot_e             slot,
   output logic [CIDX_W-1:0] ctrl_idx,
   output logic [WIDX_W-1:0] wave_idx,
   output logic [BYTE_W-1:0] rd_mask
);
   localparam logic [ADDR_W-1:0] C_LO = ADDR_W'(CTRL_FIRST);
   localparam logic [ADDR_W-1:0] C_HI = ADDR_W'(CTRL_LAST);
   localparam logic [ADDR_W-1:0] W_LO = ADDR_W'(WAVE_BASE);
   localparam logic [ADDR_W-1:0] W_HI = ADDR_W'(WAVE_BASE + WAVE_DEPTH - 1);

   always_comb begin
      slot = SLOT_NONE;
      if (addr >= C_LO && addr <= C_HI)
         slot = is_hole(8'(addr)) ? SLOT_HOLE : SLOT_CTRL;
      else if (addr >= W_LO && addr <= W_HI)
         slot = SLOT_WAVE;
   end

   assign ctrl_idx = CIDX_W'(addr - C_LO);
   assign wave_idx = WIDX_W'(addr - W_LO);
   assign rd_mask  = ctrl_read_mask(8'(addr));

endmodule

// File: rtl/sndrf_byte_bank.sv
`timescale 1ns/1ps
module sndrf_byte_bank
   import sndrf_pkg::*;
#(
   parameter int DEPTH = 23,
   parameter int IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      always_ff @(posedge clk) begin
         if (rst)
            q[i] <= '0;
         else if (we && idx == IDX_W'(i))
            q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (idx == IDX_W'(i)) rdata = q[i];
   end

endmodule

// File: rtl/sndrf_silence.sv
`timescale 1ns/1ps
module sndrf_silence #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (cnt != CNT_MAX)
         cnt <= cnt + 1'b1;
   end

   a_r9_clear: assert property (@(posedge clk) disable iff (rst)
      $past(clr) |-> cnt == '0);

   a_r10_count: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(clr) && $past(cnt) != CNT_MAX) |-> cnt == $past(cnt) + 1'b1);

   a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(clr) && $past(cnt) == CNT_MAX) |-> cnt == CNT_MAX);

endmodule

// File: rtl/sound_regfile.sv
`timescale 1ns/1ps
module sound_regfile
   import sndrf_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int CTRL_FIRST = 16,
   parameter int CTRL_LAST  = 38,
   parameter int WAVE_BASE  = 48,
   parameter int WAVE_DEPTH = 16,
   parameter int CNT_W      = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [BYTE_W-1:0] rdata,
   output logic              hit,
   output logic              note,
   output logic              log_valid,
   output logic [ADDR_W-1:0] log_addr,
   output logic [BYTE_W-1:0] log_data,
   output logic [CNT_W-1:0]  silence_cnt
);
   localparam int CTRL_NUM = CTRL_LAST - CTRL_FIRST + 1;
   localparam int CIDX_W   = $clog2(CTRL_NUM);
   localparam int WIDX_W   = $clog2(WAVE_DEPTH);

   if (ADDR_W != 8) begin : g_bad_addr
      $error("sound_regfile: read masks are keyed by an 8-bit page offset");
   end
   if (WAVE_DEPTH < 2 || (WAVE_DEPTH & (WAVE_DEPTH - 1)) != 0) begin : g_bad_wave
      $error("sound_regfile: WAVE_DEPTH must be a power of two");
   end
   if (CTRL_LAST >= WAVE_BASE || CTRL_FIRST > CTRL_LAST) begin : g_bad_ranges
      $error("sound_regfile: control and waveform ranges overlap");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("sound_regfile: CNT_W too small");
   end

   slot_e             slot;
   logic [CIDX_W-1:0] ctrl_idx;
   logic [WIDX_W-1:0] wave_idx;
   logic [BYTE_W-1:0] rd_mask;
   logic [BYTE_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] wave_q;
   logic              access;
   logic              accept;

   sndrf_decode #(
      .ADDR_W(ADDR_W), .CTRL_FIRST(CTRL_FIRST), .CTRL_LAST(CTRL_LAST),
      .WAVE_BASE(WAVE_BASE), .WAVE_DEPTH(WAVE_DEPTH),
      .CIDX_W(CIDX_W), .WIDX_W(WIDX_W)
   ) u_decode (
      .addr(addr), .slot(slot), .ctrl_idx(ctrl_idx),
      .wave_idx(wave_idx), .rd_mask(rd_mask)
   );

   sndrf_byte_bank #(.DEPTH(CTRL_NUM), .IDX_W(CIDX_W)) u_ctrl (
      .clk(clk), .rst(rst), .we(wr_en && slot == SLOT_CTRL),
      .idx(ctrl_idx), .wdata(wdata), .rdata(ctrl_q)
   );

   sndrf_byte_bank #(.DEPTH(WAVE_DEPTH), .IDX_W(WIDX_W)) u_wave (
      .clk(clk), .rst(rst), .we(wr_en && slot == SLOT_WAVE),
      .idx(wave_idx), .wdata(wdata), .rdata(wave_q)
   );

   sndrf_silence #(.CNT_W(CNT_W)) u_silence (
      .clk(clk), .rst(rst), .clr(accept), .cnt(silence_cnt)
   );

   assign access = rd_en || wr_en;
   assign hit    = access && slot != SLOT_NONE;
   assign note   = access && slot == SLOT_HOLE;
   assign accept = wr_en && slot != SLOT_NONE;

   always_comb begin
      case (slot)
         SLOT_CTRL: rdata = ctrl_q | rd_mask;
         SLOT_WAVE: rdata = wave_q;
         default:   rdata = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         log_valid <= 1'b0;
         log_addr  <= '0;
         log_data  <= '0;
      end else begin
         log_valid <= wr_en;
         if (wr_en) begin
            log_addr <= addr;
            log_data <= wdata;
         end
      end
   end

   a_r2_mask_forced: assert property (@(posedge clk) disable iff (rst)
      (rd_en && slot == SLOT_CTRL) |-> (rdata & rd_mask) == rd_mask);

   a_r5_hole_read: assert property (@(posedge clk) disable iff (rst)
      (rd_en && slot == SLOT_HOLE) |-> (rdata == 8'hFF && hit && note));

   a_r7_unhandled: assert property (@(posedge clk) disable iff (rst)
      (access && slot == SLOT_NONE) |-> (!hit && !note && rdata == 8'hFF));

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !access |-> (!hit && !note));

   a_r6_wave_roundtrip: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && $past(slot) == SLOT_WAVE && rd_en && !wr_en
       && addr == $past(addr)) |-> rdata == $past(wdata));

   a_r8_log_follows: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (log_valid == $past(wr_en)));

endmodule

// File: tb/sound_regfile_bench.sv
`timescale 1ns/1ps
module sound_regfile_bench;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic [7:0]    addr;
   logic [7:0]    wdata;
   logic          rd_en;
   logic          wr_en;
   logic [7:0]    rdata;
   logic          hit;
   logic          note;
   logic          log_valid;
   logic [7:0]    log_addr;
   logic [7:0]    log_data;
   logic [CW-1:0] silence_cnt;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   sound_regfile #(.CNT_W(CW)) u_sound_regfile (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_en(rd_en),
      .wr_en(wr_en), .rdata(rdata), .hit(hit), .note(note),
      .log_valid(log_valid), .log_addr(log_addr), .log_data(log_data),
      .silence_cnt(silence_cnt)
   );

   function automatic logic [7:0] exp_mask(input logic [7:0] a);
      case (a)
         8'h10: return 8'h80;
         8'h11, 8'h16: return 8'h3F;
         8'h14, 8'h19, 8'h1E, 8'h23: return 8'hBF;
         8'h1A: return 8'h7F;
         8'h20: return 8'hC0;
         8'h26: return 8'h70;
         8'h13, 8'h18, 8'h1D, 8'h22: return 8'hFF;
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit f_hole(input logic [7:0] a);
      return a == 8'h15 || a == 8'h1F;
   endfunction

   function automatic bit f_ctrl(input logic [7:0] a);
      return a >= 8'h10 && a <= 8'h26 && !f_hole(a);
   endfunction

   function automatic bit f_wave(input logic [7:0] a);
      return a >= 8'h30 && a <= 8'h3F;
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] stored);
      if (f_ctrl(a)) return exp_mask(a) | stored;
      if (f_wave(a)) return stored;
      return 8'hFF;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [7:0] a, input logic [7:0] stored, input string req);
      bit eh;
      @(negedge clk);
      addr = a; rd_en = 1'b1; wr_en = 1'b0;
      #1;
      eh = f_ctrl(a) || f_hole(a) || f_wave(a);
      chk(rdata == exp_read(a, stored), req, rdata, exp_read(a, stored));
      chk(hit == eh, "R7 hit", hit, eh);
      chk(note == f_hole(a), "R5 note", note, f_hole(a));
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      bit eh;
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
      #1;
      eh = f_ctrl(a) || f_hole(a) || f_wave(a);
      chk(hit == eh, "R7 write hit", hit, eh);
      @(negedge clk);
      wr_en = 1'b0;
      chk(log_valid && log_addr == a && log_data == d, "R8 log",
          {log_valid, log_addr, log_data}, {1'b1, a, d});
   endtask

   function automatic logic [7:0] pat(input logic [7:0] a, input int k);
      return 8'(a * (37 + 2 * k) + 11 + 90 * k);
   endfunction

   initial begin
      logic [CW-1:0] c0;
      rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      chk(silence_cnt == 0, "R1 counter reset", silence_cnt, 0);
      chk(log_valid == 1'b0, "R1 log reset", log_valid, 0);
      rst = 1'b0;

      // R10: idle counting
      @(negedge clk);
      c0 = silence_cnt;
      #1;
      chk(hit == 1'b0 && note == 1'b0, "R12 idle", {hit, note}, 0);
      repeat (10) @(negedge clk);
      chk(silence_cnt == c0 + 10, "R10 count", silence_cnt, c0 + 10);
      chk(log_valid == 1'b0, "R8 no log idle", log_valid, 0);

      // R7: unhandled write does not clear
      c0 = silence_cnt;
      do_write(8'h27, 8'h55);
      chk(silence_cnt == c0 + 2, "R7 counter kept", silence_cnt, c0 + 2);

      // R9: hole write clears
      do_write(8'h15, 8'hAA);
      chk(silence_cnt == 0, "R9 hole clears", silence_cnt, 0);
      repeat (3) @(negedge clk);
      chk(silence_cnt == 3, "R10 after clear", silence_cnt, 3);

      // R10 saturation, then R9 clear at ceiling
      repeat (300) @(negedge clk);
      chk(silence_cnt == {CW{1'b1}}, "R10 saturate", silence_cnt, {CW{1'b1}});
      do_write(8'h24, 8'h01);
      chk(silence_cnt == 0, "R9 clear from max", silence_cnt, 0);
      @(negedge clk);
      chk(silence_cnt == 1, "R10 restart", silence_cnt, 1);

      // R1: reset contents
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int a = 0; a < 256; a++) do_read(8'(a), 8'h00, "R1 reset read");

      // R2/R3/R4/R5/R6 sweeps with two patterns
      for (int k = 0; k < 2; k++) begin
         for (int a = 0; a < 256; a++) do_write(8'(a), pat(8'(a), k));
         for (int a = 0; a < 256; a++) begin
            if (exp_mask(8'(a)) == 8'hFF)
               do_read(8'(a), pat(8'(a), k), "R3 pitch-low");
            else if (f_hole(8'(a)))
               do_read(8'(a), pat(8'(a), k), "R5 hole");
            else if (f_wave(8'(a)))
               do_read(8'(a), pat(8'(a), k), "R6 wave");
            else if (f_ctrl(8'(a)) && exp_mask(8'(a)) == 8'h00)
               do_read(8'(a), pat(8'(a), k), "R4 plain");
            else if (f_ctrl(8'(a)))
               do_read(8'(a), pat(8'(a), k), "R2 mask");
            else
               do_read(8'(a), pat(8'(a), k), "R7 unhandled");
         end
      end

      // R11: same-cycle read and write
      do_write(8'h12, 8'h3C);
      @(negedge clk);
      addr = 8'h12; wdata = 8'hC3; rd_en = 1'b1; wr_en = 1'b1;
      #1;
      chk(rdata == 8'h3C, "R11 old value", rdata, 8'h3C);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk(rdata == 8'hC3, "R11 new value", rdata, 8'hC3);
      @(negedge clk);
      addr = 8'h30; wdata = 8'h7E; rd_en = 1'b1; wr_en = 1'b1;
      #1;
      chk(rdata == pat(8'h30, 1), "R11 wave old", rdata, pat(8'h30, 1));
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk(rdata == 8'h7E, "R11 wave new", rdata, 8'h7E);
      @(negedge clk);
      rd_en = 1'b0;
      #1;
      chk(hit == 1'b0 && note == 1'b0, "R12 strobes low", {hit, note}, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule